// File: doc/BRIEF.md
# Interrupt Redirection Dispatch Core

This block sits between a set of interrupt input pins and the processors that take interrupts. It keeps two bit vectors with one bit per pin: a pending vector that records requests and an in-service vector that records level-triggered pins whose handler has not yet signalled completion. Requests arrive one per cycle, either as a direct pin number or as a PCI device number plus INTx line that the block folds onto a pin. Mask and trigger-type bits come from a neighbouring register-access block as flat vectors. Vector, delivery type and destination are read through a single combinational table read port.

A four-state machine does the dispatch. `ST_IDLE` accepts an end-of-interrupt (EOI) or picks the highest-numbered pin that is pending and not in service (`IDLE->SCAN` or `IDLE->EVAL`). `ST_EVAL` reads that pin's entry, sets its in-service bit if the pin is level-triggered, and then either loads a delivery (`EVAL->OFFER`) or drops an unsupported type with a one-cycle warning (`EVAL->IDLE`). `ST_OFFER` holds one delivery on a valid/ready port until it is accepted (`OFFER->IDLE`). `ST_SCAN` walks the table from entry 0 upward, one entry per cycle, looking for the EOI vector. It clears the first match (`SCAN->IDLE` on a match or after the last entry).

Top module: `irq_dispatch_core`

## Requirements
- R1: After reset, `dlv_valid` and `warn_drop` are low, `eoi_ready` is high, and no pin is pending or in service.
- R2: A pin is eligible when it is pending and not in service. The highest-numbered eligible pin is dispatched first, and dispatching repeats until no pin is eligible.
- R3: On a pin whose `cfg_level` bit is 1 (level-triggered), a request with `req_level`=1 makes it pending and a request with `req_level`=0 withdraws it. A withdrawn request is never delivered.
- R4: On a pin whose `cfg_level` bit is 0 (edge-triggered), only `req_level`=1 makes it pending and `req_level`=0 has no effect. Such a pin never enters service, so it can be delivered again without an EOI.
- R5: A level-triggered pin enters service when it is dispatched. While it is in service, new requests on it are held pending and not delivered.
- R6: A request on a pin whose `cfg_mask` bit is 1, or on a pin number of `NUM_PINS` or more, is discarded and leaves nothing pending.
- R7: `dlv_valid`, `dlv_vector` and `dlv_target` stay constant until `dlv_ready` is high. The pin stops being pending in the cycle of that handshake.
- R8: An accepted EOI (`eoi_valid` with `eoi_ready`) drops `eoi_ready` and starts a scan from entry 0 upward, one entry per cycle, with no dispatch during the scan. The first entry whose vector equals the EOI vector has its in-service bit cleared, and any pending request on that pin is then dispatched. With no match, the scan visits all `NUM_PINS` entries and changes nothing.
- R9: Delivery type 0 (fixed) sends the entry's vector to the entry's destination. Type 1 (lowest priority) sends it to `ovr_target` when `ovr_valid` is 1, and otherwise to the entry's destination.
- R10: Any other delivery type is not delivered. `warn_drop` pulses for one cycle and the pin stops being pending, and a level-triggered pin still enters service.
- R11: A PCI request with device `d` and line `i` acts on pin (((4d + floor(d/8) + i) mod 32) + 16).
- R12: A request taken at clock edge N onto an idle block shows `dlv_valid` (or `warn_drop`) after edge N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request event this cycle |
| req_is_pci | input | 1 | 1: pin comes from `req_dev`/`req_intx`; 0: from `req_pin` |
| req_pin | input | PIN_W | Direct pin number |
| req_dev | input | 5 | PCI device number |
| req_intx | input | 2 | PCI INTx line (0..3) |
| req_level | input | 1 | Requested line level |
| cfg_mask | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfg_level | input | NUM_PINS | Per-pin trigger, 1 = level, 0 = edge |
| tbl_idx | output | PIN_W | Table entry being read |
| tbl_vector | input | VEC_W | Vector of entry `tbl_idx` |
| tbl_mode | input | 3 | Delivery type of entry `tbl_idx` |
| tbl_dest | input | DEST_W | Destination of entry `tbl_idx` |
| ovr_valid | input | 1 | Lowest-priority override target is valid |
| ovr_target | input | DEST_W | Lowest-priority override target |
| eoi_valid | input | 1 | EOI offered |
| eoi_vector | input | VEC_W | EOI vector |
| eoi_ready | output | 1 | EOI can be accepted (idle) |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Delivery accepted |
| dlv_vector | output | VEC_W | Delivered vector |
| dlv_target | output | DEST_W | Delivery target |
| warn_drop | output | 1 | One-cycle pulse on an unsupported delivery type |

## Verification
The pending vector is written on the request edge, the winner is latched on the next edge, and the delivery or warning is loaded on the edge after that. So `dlv_valid` and `warn_drop` are due two edges after the request edge, and the bench checks both that they are low one edge earlier and that they are high on time. `eoi_ready` falls on the edge that accepts an EOI. An unmatched scan keeps it low for exactly `NUM_PINS` cycles, which the bench counts. All outputs are sampled on the falling edge, and inputs change only on the falling edge. Checks that something was ignored watch the delivery port for a fixed window long enough to cover a full scan and dispatch.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_OFFER = 2'd2,
        ST_SCAN  = 2'd3
    } disp_state_t;

    localparam logic [2:0] DM_FIXED  = 3'd0;
    localparam logic [2:0] DM_LOWEST = 3'd1;

    function automatic logic mode_deliverable(input logic [2:0] mode);
        return (mode == DM_FIXED) || (mode == DM_LOWEST);
    endfunction

endpackage

// File: rtl/irq_pci_pin_map.sv
module irq_pci_pin_map #(
    parameter int PIN_W = 6
) (
    input  logic [4:0]       dev,
    input  logic [1:0]       intx,
    output logic [PIN_W-1:0] pin
);
    logic [7:0] sum;
    logic [5:0] pin6;

    always_comb begin
        sum  = {1'b0, dev, 2'b00} + {6'b0, dev[4:3]} + {6'b0, intx};
        pin6 = {1'b0, sum[4:0]} + 6'd16;
        pin  = PIN_W'(pin6);
    end
endmodule

// File: rtl/irq_pending_regs.sv
module irq_pending_regs #(
    parameter int NUM_PINS = 48,
    parameter int PIN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PIN_W-1:0]    req_pin,
    input  logic                req_level,
    input  logic [NUM_PINS-1:0] cfg_mask,
    input  logic [NUM_PINS-1:0] cfg_level,
    input  logic                irr_clr,
    input  logic                isr_set,
    input  logic [PIN_W-1:0]    svc_pin,
    input  logic                isr_clr,
    input  logic [PIN_W-1:0]    clr_pin,
    output logic [NUM_PINS-1:0] irr,
    output logic [NUM_PINS-1:0] isr
);
    localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

    logic [NUM_PINS-1:0] irr_d, isr_d;
    logic                req_ok;

    always_comb begin
        req_ok = req_valid && (req_pin <= LAST_PIN);
        irr_d  = irr;
        if (irr_clr)
            irr_d[svc_pin] = 1'b0;
        if (req_ok && !cfg_mask[req_pin]) begin
            if (req_level)
                irr_d[req_pin] = 1'b1;
            else if (cfg_level[req_pin])
                irr_d[req_pin] = 1'b0;
        end
        isr_d = isr;
        if (isr_set)
            isr_d[svc_pin] = 1'b1;
        if (isr_clr)
            isr_d[clr_pin] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= irr_d;
            isr <= isr_d;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_PINS = 48,
    parameter int PIN_W    = 6
) (
    input  logic [NUM_PINS-1:0] elig,
    output logic                any,
    output logic [PIN_W-1:0]    idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (elig[i]) begin
                any = 1'b1;
                idx = PIN_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_dispatch_core.sv
module irq_dispatch_core
    import irq_dispatch_pkg::*;
#(
    parameter int NUM_PINS = 48,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 16,
    parameter int PIN_W    = ($clog2(NUM_PINS) < 6) ? 6 : $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_is_pci,
    input  logic [PIN_W-1:0]    req_pin,
    input  logic [4:0]          req_dev,
    input  logic [1:0]          req_intx,
    input  logic                req_level,
    input  logic [NUM_PINS-1:0] cfg_mask,
    input  logic [NUM_PINS-1:0] cfg_level,
    output logic [PIN_W-1:0]    tbl_idx,
    input  logic [VEC_W-1:0]    tbl_vector,
    input  logic [2:0]          tbl_mode,
    input  logic [DEST_W-1:0]   tbl_dest,
    input  logic                ovr_valid,
    input  logic [DEST_W-1:0]   ovr_target,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vector,
    output logic                eoi_ready,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output logic [VEC_W-1:0]    dlv_vector,
    output logic [DEST_W-1:0]   dlv_target,
    output logic                warn_drop
);
    localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

    disp_state_t         state_q, state_d;
    logic [PIN_W-1:0]    cur_pin_q, scan_idx_q, pci_pin, eff_pin, win_pin;
    logic [VEC_W-1:0]    eoi_vec_q;
    logic [NUM_PINS-1:0] irr_vec, isr_vec;
    logic                win_any;
    logic                irr_clr, isr_set, isr_clr, load_dlv, drop, take_pin, start_scan, scan_step;

    irq_pci_pin_map #(.PIN_W(PIN_W)) u_map (
        .dev (req_dev),
        .intx(req_intx),
        .pin (pci_pin)
    );

    assign eff_pin = req_is_pci ? pci_pin : req_pin;

    irq_pending_regs #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_pin  (eff_pin),
        .req_level(req_level),
        .cfg_mask (cfg_mask),
        .cfg_level(cfg_level),
        .irr_clr  (irr_clr),
        .isr_set  (isr_set),
        .svc_pin  (cur_pin_q),
        .isr_clr  (isr_clr),
        .clr_pin  (scan_idx_q),
        .irr      (irr_vec),
        .isr      (isr_vec)
    );

    irq_prio_pick #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pick (
        .elig(irr_vec & ~isr_vec),
        .any (win_any),
        .idx (win_pin)
    );

    assign tbl_idx = (state_q == ST_SCAN) ? scan_idx_q : cur_pin_q;

    // next state and control strobes
    always_comb begin
        state_d    = state_q;
        irr_clr    = 1'b0;
        isr_set    = 1'b0;
        isr_clr    = 1'b0;
        load_dlv   = 1'b0;
        drop       = 1'b0;
        take_pin   = 1'b0;
        start_scan = 1'b0;
        scan_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (eoi_valid) begin
                    start_scan = 1'b1;
                    state_d    = ST_SCAN;
                end else if (win_any) begin
                    take_pin = 1'b1;
                    state_d  = ST_EVAL;
                end
            end
            ST_EVAL: begin
                isr_set = cfg_level[cur_pin_q];
                if (mode_deliverable(tbl_mode)) begin
                    load_dlv = 1'b1;
                    state_d  = ST_OFFER;
                end else begin
                    drop    = 1'b1;
                    irr_clr = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_OFFER: begin
                if (dlv_ready) begin
                    irr_clr = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (tbl_vector == eoi_vec_q) begin
                    isr_clr = 1'b1;
                    state_d = ST_IDLE;
                end else if (scan_idx_q == LAST_PIN) begin
                    state_d = ST_IDLE;
                end else begin
                    scan_step = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // registered outputs and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pin_q  <= '0;
            scan_idx_q <= '0;
            eoi_vec_q  <= '0;
            dlv_vector <= '0;
            dlv_target <= '0;
            warn_drop  <= 1'b0;
        end else begin
            warn_drop <= drop;
            if (take_pin)
                cur_pin_q <= win_pin;
            if (start_scan) begin
                scan_idx_q <= '0;
                eoi_vec_q  <= eoi_vector;
            end else if (scan_step) begin
                scan_idx_q <= scan_idx_q + 1'b1;
            end
            if (load_dlv) begin
                dlv_vector <= tbl_vector;
                dlv_target <= ((tbl_mode == DM_LOWEST) && ovr_valid) ? ovr_target : tbl_dest;
            end
        end
    end

    assign dlv_valid = (state_q == ST_OFFER);
    assign eoi_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker #(
    parameter int NUM_PINS = 48,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 16,
    parameter int PIN_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_is_pci,
    input logic [PIN_W-1:0]    req_pin,
    input logic [NUM_PINS-1:0] cfg_mask,
    input logic [NUM_PINS-1:0] cfg_level,
    input logic                eoi_valid,
    input logic                eoi_ready,
    input logic                dlv_valid,
    input logic                dlv_ready,
    input logic [VEC_W-1:0]    dlv_vector,
    input logic [DEST_W-1:0]   dlv_target,
    input logic                warn_drop,
    input logic [NUM_PINS-1:0] irr_vec,
    input logic [NUM_PINS-1:0] isr_vec,
    input logic [PIN_W-1:0]    cur_pin_q
);
    localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

    p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector) && $stable(dlv_target));

    p_clear_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && dlv_ready && !req_valid |=> !irr_vec[$past(cur_pin_q)]);

    p_ignore_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_is_pci && ((req_pin > LAST_PIN) || cfg_mask[req_pin])
        |=> (irr_vec & ~$past(irr_vec)) == '0);

    p_service_level_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_vec & ~$past(isr_vec)) & ~$past(cfg_level)) == '0);

    p_scan_blocks_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid && eoi_ready |=> !dlv_valid && !eoi_ready);

    p_warn_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        warn_drop |=> !warn_drop);

    p_warn_no_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        warn_drop |-> !dlv_valid);
endmodule

bind irq_dispatch_core irq_dispatch_checker #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .PIN_W(PIN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_is_pci(req_is_pci),
    .req_pin   (req_pin),
    .cfg_mask  (cfg_mask),
    .cfg_level (cfg_level),
    .eoi_valid (eoi_valid),
    .eoi_ready (eoi_ready),
    .dlv_valid (dlv_valid),
    .dlv_ready (dlv_ready),
    .dlv_vector(dlv_vector),
    .dlv_target(dlv_target),
    .warn_drop (warn_drop),
    .irr_vec   (irr_vec),
    .isr_vec   (isr_vec),
    .cur_pin_q (cur_pin_q)
);

// File: tb/irq_dispatch_core_bench.sv
module irq_dispatch_core_bench;
    localparam int NP = 48;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_is_pci = 1'b0, req_level = 1'b0;
    logic [PW-1:0] req_pin = '0;
    logic [4:0]    req_dev = '0;
    logic [1:0]    req_intx = '0;
    logic [NP-1:0] cfg_mask = '1, cfg_level = '0;
    logic [PW-1:0] tbl_idx;
    logic [7:0]    tbl_vector;
    logic [2:0]    tbl_mode;
    logic [15:0]   tbl_dest;
    logic          ovr_valid = 1'b0;
    logic [15:0]   ovr_target = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          eoi_ready, dlv_valid, warn_drop;
    logic          dlv_ready = 1'b0;
    logic [7:0]    dlv_vector;
    logic [15:0]   dlv_target;

    logic [7:0]  t_vec  [NP];
    logic [2:0]  t_mode [NP];
    logic [15:0] t_dest [NP];

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        tbl_vector = t_vec[tbl_idx];
        tbl_mode   = t_mode[tbl_idx];
        tbl_dest   = t_dest[tbl_idx];
    end

    irq_dispatch_core u_irq_dispatch_core (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_pci(req_is_pci),
        .req_pin(req_pin), .req_dev(req_dev), .req_intx(req_intx), .req_level(req_level),
        .cfg_mask(cfg_mask), .cfg_level(cfg_level), .tbl_idx(tbl_idx),
        .tbl_vector(tbl_vector), .tbl_mode(tbl_mode), .tbl_dest(tbl_dest),
        .ovr_valid(ovr_valid), .ovr_target(ovr_target), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .eoi_ready(eoi_ready), .dlv_valid(dlv_valid),
        .dlv_ready(dlv_ready), .dlv_vector(dlv_vector), .dlv_target(dlv_target),
        .warn_drop(warn_drop)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_pin(input int pin, input logic [7:0] vec, input logic [2:0] mode,
                           input bit lvl, input logic [15:0] dest);
        t_vec[pin] = vec; t_mode[pin] = mode; t_dest[pin] = dest;
        cfg_level[pin] = lvl; cfg_mask[pin] = 1'b0;
    endtask

    task automatic send_req(input int pin, input bit lvl);
        @(negedge clk);
        req_valid = 1'b1; req_is_pci = 1'b0; req_pin = PW'(pin); req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_pci(input logic [4:0] dev, input logic [1:0] ln);
        @(negedge clk);
        req_valid = 1'b1; req_is_pci = 1'b1; req_dev = dev; req_intx = ln; req_level = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_is_pci = 1'b0;
    endtask

    task automatic wait_dlv(input logic [7:0] ev, input logic [15:0] et, input string tag);
        int n = 0;
        while (!dlv_valid && n < 150) begin @(negedge clk); n++; end
        chk(dlv_valid, {tag, " offered"}, int'(dlv_valid), 1);
        chk(dlv_vector == ev, {tag, " vector"}, int'(dlv_vector), int'(ev));
        chk(dlv_target == et, {tag, " target"}, int'(dlv_target), int'(et));
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (dlv_valid) seen++;
        end
        chk(seen == 0, {tag, " no delivery"}, seen, 0);
    endtask

    task automatic send_eoi(input logic [7:0] v);
        int n = 0;
        while (!eoi_ready && n < 150) begin @(negedge clk); n++; end
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(!dlv_valid, "R1 dlv_valid", int'(dlv_valid), 0);
        chk(eoi_ready, "R1 eoi_ready", int'(eoi_ready), 1);
        chk(!warn_drop, "R1 warn_drop", int'(warn_drop), 0);
        expect_quiet(5, "R1 idle");
    endtask

    task automatic t_priority;
        cfg_pin(3, 8'h03, 3'd0, 1'b0, 16'h0103);
        cfg_pin(5, 8'h05, 3'd0, 1'b0, 16'h0105);
        cfg_pin(20, 8'h14, 3'd0, 1'b0, 16'h0114);
        cfg_pin(40, 8'h28, 3'd0, 1'b0, 16'h0128);
        send_req(3, 1'b1);
        @(negedge clk);
        chk(!dlv_valid, "R12 not early", int'(dlv_valid), 0);
        @(negedge clk);
        chk(dlv_valid, "R12 on time", int'(dlv_valid), 1);
        send_req(5, 1'b1); send_req(40, 1'b1); send_req(20, 1'b1);
        chk(dlv_valid && dlv_vector == 8'h03, "R7 held offer", int'(dlv_vector), 3);
        wait_dlv(8'h03, 16'h0103, "R7 first");
        wait_dlv(8'h28, 16'h0128, "R2 pin40");
        wait_dlv(8'h14, 16'h0114, "R2 pin20");
        wait_dlv(8'h05, 16'h0105, "R2 pin5");
        expect_quiet(8, "R2 drained");
    endtask

    task automatic t_level;
        cfg_pin(10, 8'h50, 3'd0, 1'b1, 16'h000A);
        send_req(10, 1'b1);
        wait_dlv(8'h50, 16'h000A, "R5 first");
        send_req(10, 1'b1);
        expect_quiet(12, "R5 in service");
        send_eoi(8'h50);
        chk(!eoi_ready, "R8 scanning", int'(eoi_ready), 0);
        wait_dlv(8'h50, 16'h000A, "R8 resume");
        send_eoi(8'h50);
        expect_quiet(60, "R8 cleared");
        send_req(3, 1'b1);
        send_req(10, 1'b1);
        send_req(10, 1'b0);
        wait_dlv(8'h03, 16'h0103, "R3 occupier");
        expect_quiet(10, "R3 withdrawn");
    endtask

    task automatic t_edge;
        cfg_pin(7, 8'h07, 3'd0, 1'b0, 16'h0107);
        send_req(3, 1'b1);
        send_req(7, 1'b1);
        send_req(7, 1'b0);
        wait_dlv(8'h03, 16'h0103, "R4 occupier");
        wait_dlv(8'h07, 16'h0107, "R4 kept");
        send_req(7, 1'b1);
        wait_dlv(8'h07, 16'h0107, "R4 again");
    endtask

    task automatic t_mask;
        t_vec[12] = 8'h0C; t_mode[12] = 3'd0; t_dest[12] = 16'h010C; cfg_level[12] = 1'b0;
        send_req(12, 1'b1);
        expect_quiet(10, "R6 masked");
        send_req(60, 1'b1);
        expect_quiet(10, "R6 range");
        cfg_mask[12] = 1'b0;
        expect_quiet(10, "R6 nothing stored");
    endtask

    task automatic t_eoi;
        int lo = 0;
        cfg_pin(14, 8'h66, 3'd0, 1'b1, 16'h000E);
        cfg_pin(30, 8'h66, 3'd0, 1'b1, 16'h001E);
        send_req(30, 1'b1);
        wait_dlv(8'h66, 16'h001E, "R8 pin30");
        send_eoi(8'h66);
        send_req(30, 1'b1);
        expect_quiet(60, "R8 first match is pin14");
        t_vec[14] = 8'h67;
        send_eoi(8'h66);
        wait_dlv(8'h66, 16'h001E, "R8 pin30 released");
        send_eoi(8'h66);
        expect_quiet(60, "R8 settle");
        send_eoi(8'hEE);
        while (!eoi_ready && lo < 200) begin lo++; @(negedge clk); end
        chk(lo == NP, "R8 unmatched scan length", lo, NP);
        expect_quiet(5, "R8 unmatched");
    endtask

    task automatic t_modes;
        cfg_pin(22, 8'h22, 3'd1, 1'b0, 16'h0016);
        cfg_pin(21, 8'h21, 3'd0, 1'b0, 16'h0015);
        send_req(22, 1'b1);
        wait_dlv(8'h22, 16'h0016, "R9 lowest no override");
        ovr_valid = 1'b1; ovr_target = 16'h0ABC;
        send_req(22, 1'b1);
        wait_dlv(8'h22, 16'h0ABC, "R9 lowest override");
        send_req(21, 1'b1);
        wait_dlv(8'h21, 16'h0015, "R9 fixed ignores override");
        ovr_valid = 1'b0;
        cfg_pin(23, 8'h23, 3'd4, 1'b0, 16'h0017);
        send_req(23, 1'b1);
        @(negedge clk);
        chk(!warn_drop, "R10 warn not early", int'(warn_drop), 0);
        @(negedge clk);
        chk(warn_drop, "R10 warn pulse", int'(warn_drop), 1);
        @(negedge clk);
        chk(!warn_drop, "R10 warn one cycle", int'(warn_drop), 0);
        expect_quiet(10, "R10 dropped");
        cfg_pin(24, 8'h24, 3'd2, 1'b1, 16'h0018);
        send_req(24, 1'b1);
        expect_quiet(6, "R10 dropped level");
        t_mode[24] = 3'd0;
        send_req(24, 1'b1);
        expect_quiet(10, "R10 level still in service");
        send_eoi(8'h24);
        wait_dlv(8'h24, 16'h0018, "R10 after EOI");
        send_eoi(8'h24);
        expect_quiet(60, "R10 settle");
    endtask

    task automatic t_pci;
        cfg_pin(28, 8'h1C, 3'd0, 1'b0, 16'h011C);
        cfg_pin(18, 8'h12, 3'd0, 1'b0, 16'h0112);
        send_pci(5'd3, 2'd0);
        wait_dlv(8'h1C, 16'h011C, "R11 dev3 line0");
        send_pci(5'd31, 2'd3);
        wait_dlv(8'h12, 16'h0112, "R11 dev31 line3");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            t_vec[i] = 8'h00; t_mode[i] = 3'd0; t_dest[i] = 16'h0000;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_level();
        t_edge();
        t_mask();
        t_eoi();
        t_modes();
        t_pci();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule